// File: doc/BRIEF.md
# Single-Channel Register-Programmed DMA Engine

This block is one channel of a small peripheral DMA controller. Software programs a source address, a destination address, a cycle count and a control word through a 32-bit register port. It then sets the enable bit. The engine copies data one beat at a time over a generic single-beat master port. Each beat is a read from the source address followed by a write of that data to the destination address. After each beat, each address moves by its own signed step. A cycle is one beat in single mode and four beats in burst mode.

Either side can be tied to a peripheral request line. The engine then waits for that request before each cycle and acknowledges it once the cycle ends. The cycle counter counts down in place, so software can read back the remaining work at any time. When the count runs out the engine stops and raises a finish flag. A bus error stops it and raises an error flag. Either flag can drive the interrupt output.

Top module: `dma_chan_engine`

## Requirements
- R1: Registers are selected by `reg_addr[3:2]`: 0 source address, 1 destination address, 2 cycle count, 3 control. A read returns the value one clock after the request, and all registers reset to 0. The count is 24 bits wide and its upper 8 read bits are 0. Control bits 11, 15, 22, 23 and 31:28 are not stored and read as 0.
- R2: The status bits are control bit 1 (finish) and bit 4 (error). A register write of 0 to a status bit clears it. A write of 1 to a status bit leaves it unchanged.
- R3: Each beat reads the source address and then writes the data read to the destination address. `m_size` carries control bits 21:20 (00 word, 01 half-word, 10 byte). `m_sys` carries control bit 6 on reads and control bit 7 on writes.
- R4: Each address has its own 3-bit step code: bits 10:8 for the source and bits 14:12 for the destination. Codes 001/010/011 add 1/2/4 and codes 101/110/111 subtract 1/2/4. Codes 000 and 100 leave the address unchanged. The source steps after every accepted read and the destination after every accepted write. Control bit 3 (burst) makes a cycle four beats instead of one.
- R5: The count register decrements by one at the end of every cycle, and reading it during a transfer returns the cycles still to do.
- R6: When the last cycle completes, enable (bit 0) clears and finish (bit 1) sets. If enable is set with a count of 0, the engine finishes at once without any bus access. No bus request is made while enable is 0.
- R7: If a beat is accepted with `m_err` high, enable clears, error (bit 4) sets and no further bus request is made. The failed read does not step its address.
- R8: `irq` equals, one clock later, (finish AND bit 2) OR (error AND bit 5).
- R9: The source request line is selected by bits 27:24 and the destination request line by bits 19:16. When a selector is nonzero, a cycle starts only while `periph_req` at that line is high. After the cycle's last write, `periph_ack` at each selected line is high for exactly one clock.
- R10: Writes to the source, destination and count registers are ignored while enable is 1.
- R11: Once `m_valid` is high, `m_valid`, `m_write`, `m_addr` and `m_wdata` hold until `m_ready` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 4 | Byte offset within the channel |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| m_valid | output | 1 | Master request valid |
| m_write | output | 1 | 1 = write beat, 0 = read beat |
| m_addr | output | ADDR_W | Beat address |
| m_wdata | output | DATA_W | Write data |
| m_size | output | 2 | Transfer width code |
| m_sys | output | 1 | Bus select for this beat (1 = system bus) |
| m_ready | input | 1 | Beat accepted this clock |
| m_rdata | input | DATA_W | Read data, valid with m_ready |
| m_err | input | 1 | Error response, valid with m_ready |
| periph_req | input | LINES | Peripheral request lines |
| periph_ack | output | LINES | One-clock acknowledge pulses |
| irq | output | 1 | Interrupt |

## Verification
Some properties hold on every clock, and the assertions check those. The master request stays stable until it is accepted. The bus is quiet while enable is low. An error response stops the engine at the next edge. The interrupt tracks the status and enable bits with one clock of lag. Each acknowledge is a single-clock pulse that follows an accepted write.

Other behaviour needs the bench's scenarios. These cover the full sweep of both step-code fields with burst on and off, and the exact address and data sequence of each transfer. They also cover live count readback while the engine waits on a handshake, the zero-count start, and the write-0-to-clear status semantics.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  // control word bit positions (decoded by the engine)
  localparam int CB_EN      = 0;
  localparam int CB_FIN     = 1;
  localparam int CB_FIN_IE  = 2;
  localparam int CB_BURST   = 3;
  localparam int CB_ERR     = 4;
  localparam int CB_ERR_IE  = 5;
  localparam int CB_SRC_SYS = 6;
  localparam int CB_DST_SYS = 7;
  localparam int CB_SRC_STEP = 8;   // 3 bits
  localparam int CB_DST_STEP = 12;  // 3 bits
  localparam int CB_DST_LINE = 16;  // 4 bits
  localparam int CB_WIDTH    = 20;  // 2 bits
  localparam int CB_SRC_LINE = 24;  // 4 bits

  localparam logic [31:0] CTRL_KEEP   = 32'h0F3F_77FF;
  localparam logic [31:0] CTRL_STATUS = 32'h0000_0012;

  localparam logic [1:0] RSEL_SRC  = 2'd0;
  localparam logic [1:0] RSEL_DST  = 2'd1;
  localparam logic [1:0] RSEL_CNT  = 2'd2;
  localparam logic [1:0] RSEL_CTRL = 2'd3;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_WAIT  = 2'd1,
    XS_READ  = 2'd2,
    XS_WRITE = 2'd3
  } xfer_state_t;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic [2:0]        code,
  input  logic [ADDR_W-1:0] cur,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] mag;

  always_comb begin
    case (code[1:0])
      2'b01:   mag = ADDR_W'(1);
      2'b10:   mag = ADDR_W'(2);
      2'b11:   mag = ADDR_W'(4);
      default: mag = '0;
    endcase
    nxt = code[2] ? (cur - mag) : (cur + mag);
  end
endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_chan_pkg::*;
#(
  parameter int LINES       = 16,
  parameter int BURST_BEATS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     burst,
  input  logic                     cnt_zero,
  input  logic                     cnt_one,
  input  logic [$clog2(LINES)-1:0] src_line,
  input  logic [$clog2(LINES)-1:0] dst_line,
  input  logic [LINES-1:0]         periph_req,
  input  logic                     bus_ready,
  input  logic                     bus_err,
  output logic                     bus_valid,
  output logic                     bus_write,
  output logic                     rd_ok,
  output logic                     wr_ok,
  output logic                     cyc_done,
  output logic                     fin_evt,
  output logic                     err_evt
);
  localparam int BEAT_W = $clog2(BURST_BEATS);

  xfer_state_t       state_q;
  logic [BEAT_W-1:0] beat_q;
  logic              last_beat;
  logic              hs_ok;

  always_comb begin
    hs_ok     = ((src_line == '0) || periph_req[src_line]) &&
                ((dst_line == '0) || periph_req[dst_line]);
    last_beat = !burst || (beat_q == BEAT_W'(BURST_BEATS - 1));
    bus_valid = (state_q == XS_READ) || (state_q == XS_WRITE);
    bus_write = (state_q == XS_WRITE);
    rd_ok     = (state_q == XS_READ)  && bus_ready && !bus_err;
    wr_ok     = (state_q == XS_WRITE) && bus_ready && !bus_err;
    err_evt   = bus_valid && bus_ready && bus_err;
    cyc_done  = wr_ok && last_beat;
    fin_evt   = ((state_q == XS_IDLE) && en && cnt_zero) || (cyc_done && cnt_one);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= XS_IDLE;
      beat_q  <= '0;
    end else begin
      case (state_q)
        XS_IDLE: begin
          beat_q <= '0;
          if (en && !cnt_zero) state_q <= XS_WAIT;
        end
        XS_WAIT: begin
          if (!en)        state_q <= XS_IDLE;
          else if (hs_ok) state_q <= XS_READ;
        end
        XS_READ: begin
          if (err_evt)    state_q <= XS_IDLE;
          else if (rd_ok) state_q <= XS_WRITE;
        end
        default: begin
          if (err_evt) begin
            state_q <= XS_IDLE;
          end else if (wr_ok) begin
            if (last_beat) begin
              beat_q  <= '0;
              state_q <= cnt_one ? XS_IDLE : XS_WAIT;
            end else begin
              beat_q  <= beat_q + 1'b1;
              state_q <= XS_READ;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int CNT_W       = 24,
  parameter int LINES       = 16,
  parameter int BURST_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              m_valid,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  output logic [1:0]        m_size,
  output logic              m_sys,
  input  logic              m_ready,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_err,
  input  logic [LINES-1:0]  periph_req,
  output logic [LINES-1:0]  periph_ack,
  output logic              irq
);
  localparam int LINE_W = $clog2(LINES);

  logic [ADDR_W-1:0] src_q, dst_q, src_nxt, dst_nxt;
  logic [CNT_W-1:0]  cnt_q;
  logic [31:0]       ctrl_q;
  logic [DATA_W-1:0] data_q;
  logic [31:0]       rdata_q;
  logic [LINES-1:0]  ack_q, ack_nxt;
  logic              irq_q;
  logic              rd_ok, wr_ok, cyc_done, fin_evt, err_evt;
  logic              wr_src, wr_dst, wr_cnt, wr_ctrl;
  logic [LINE_W-1:0] src_line, dst_line;

  assign src_line = ctrl_q[CB_SRC_LINE +: LINE_W];
  assign dst_line = ctrl_q[CB_DST_LINE +: LINE_W];

  always_comb begin
    wr_src  = reg_en && reg_we && (reg_addr[3:2] == RSEL_SRC)  && !ctrl_q[CB_EN];
    wr_dst  = reg_en && reg_we && (reg_addr[3:2] == RSEL_DST)  && !ctrl_q[CB_EN];
    wr_cnt  = reg_en && reg_we && (reg_addr[3:2] == RSEL_CNT)  && !ctrl_q[CB_EN];
    wr_ctrl = reg_en && reg_we && (reg_addr[3:2] == RSEL_CTRL);
  end

  dma_addr_step #(.ADDR_W(ADDR_W)) u_src_step (
    .code(ctrl_q[CB_SRC_STEP +: 3]), .cur(src_q), .nxt(src_nxt));

  dma_addr_step #(.ADDR_W(ADDR_W)) u_dst_step (
    .code(ctrl_q[CB_DST_STEP +: 3]), .cur(dst_q), .nxt(dst_nxt));

  dma_xfer_ctrl #(.LINES(LINES), .BURST_BEATS(BURST_BEATS)) u_ctrl (
    .clk(clk), .rst(rst),
    .en(ctrl_q[CB_EN]), .burst(ctrl_q[CB_BURST]),
    .cnt_zero(cnt_q == '0), .cnt_one(cnt_q == CNT_W'(1)),
    .src_line(src_line), .dst_line(dst_line), .periph_req(periph_req),
    .bus_ready(m_ready), .bus_err(m_err),
    .bus_valid(m_valid), .bus_write(m_write),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .cyc_done(cyc_done),
    .fin_evt(fin_evt), .err_evt(err_evt));

  always_comb begin
    ack_nxt = '0;
    for (int i = 1; i < LINES; i++) begin
      if (cyc_done && ((src_line == LINE_W'(i)) || (dst_line == LINE_W'(i))))
        ack_nxt[i] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      ctrl_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      ack_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (rd_ok)       src_q <= src_nxt;
      else if (wr_src) src_q <= reg_wdata[ADDR_W-1:0];

      if (wr_ok)       dst_q <= dst_nxt;
      else if (wr_dst) dst_q <= reg_wdata[ADDR_W-1:0];

      if (cyc_done)    cnt_q <= cnt_q - 1'b1;
      else if (wr_cnt) cnt_q <= reg_wdata[CNT_W-1:0];

      if (rd_ok) data_q <= m_rdata;

      if (wr_ctrl)
        ctrl_q <= (reg_wdata & CTRL_KEEP & ~CTRL_STATUS) |
                  (ctrl_q & reg_wdata & CTRL_STATUS);
      if (fin_evt) begin
        ctrl_q[CB_EN]  <= 1'b0;
        ctrl_q[CB_FIN] <= 1'b1;
      end
      if (err_evt) begin
        ctrl_q[CB_EN]  <= 1'b0;
        ctrl_q[CB_ERR] <= 1'b1;
      end

      ack_q <= ack_nxt;
      irq_q <= (ctrl_q[CB_FIN] & ctrl_q[CB_FIN_IE]) | (ctrl_q[CB_ERR] & ctrl_q[CB_ERR_IE]);

      if (reg_en && !reg_we) begin
        case (reg_addr[3:2])
          RSEL_SRC: rdata_q <= 32'(src_q);
          RSEL_DST: rdata_q <= 32'(dst_q);
          RSEL_CNT: rdata_q <= 32'(cnt_q);
          default:  rdata_q <= ctrl_q;
        endcase
      end
    end
  end

  assign reg_rdata  = rdata_q;
  assign m_addr     = m_write ? dst_q : src_q;
  assign m_wdata    = data_q;
  assign m_size     = ctrl_q[CB_WIDTH +: 2];
  assign m_sys      = m_write ? ctrl_q[CB_DST_SYS] : ctrl_q[CB_SRC_SYS];
  assign periph_ack = ack_q;
  assign irq        = irq_q;
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              m_valid,
  input logic              m_write,
  input logic [ADDR_W-1:0] m_addr,
  input logic [DATA_W-1:0] m_wdata,
  input logic              m_ready,
  input logic              m_err,
  input logic [LINES-1:0]  periph_ack,
  input logic              irq,
  input logic [31:0]       ctrl
);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_write) && $stable(m_addr) && $stable(m_wdata)));

  p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> ctrl[0]);

  p_err_stops_r7: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && m_err) |=> (!ctrl[0] && ctrl[4] && !m_valid));

  p_irq_track_r8: assert property (@(posedge clk) disable iff (rst)
    irq == $past((ctrl[1] & ctrl[2]) | (ctrl[4] & ctrl[5])));

  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    (|periph_ack) |=> (periph_ack == '0));

  p_ack_after_write_r9: assert property (@(posedge clk) disable iff (rst)
    (|periph_ack) |-> $past(m_valid && m_write && m_ready && !m_err));
endmodule

bind dma_chan_engine dma_chan_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)
) u_chk (
  .clk(clk), .rst(rst), .m_valid(m_valid), .m_write(m_write), .m_addr(m_addr),
  .m_wdata(m_wdata), .m_ready(m_ready), .m_err(m_err), .periph_ack(periph_ack),
  .irq(irq), .ctrl(ctrl_q));

// File: tb/sim_dma_chan_engine.sv
`timescale 1ns/1ps
module sim_dma_chan_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        m_valid, m_write, m_sys;
  logic [31:0] m_addr, m_wdata;
  logic [1:0]  m_size;
  logic        m_ready = 1'b0, m_err = 1'b0;
  logic [31:0] m_rdata = '0;
  logic [15:0] periph_req = '0;
  logic [15:0] periph_ack;
  logic        irq;

  int checks = 0, errors = 0;

  // bus model state
  int          tick = 0;
  bit          err_arm = 0;
  logic [31:0] err_addr = '0;
  bit          drop_mode = 0;
  int          log_n = 0;
  logic [31:0] log_addr [256];
  logic [31:0] log_data [256];
  logic [1:0]  log_size [256];
  bit          log_wr   [256];
  bit          log_sys  [256];
  int          ack_seen [16];
  int          ack_total = 0;

  always #2.5 clk = ~clk;

  dma_chan_engine u0 (
    .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .m_valid(m_valid), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_size(m_size), .m_sys(m_sys),
    .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err),
    .periph_req(periph_req), .periph_ack(periph_ack), .irq(irq));

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h0F0F_0000;
  endfunction

  function automatic int step_of(input int code);
    case (code)
      1: return 1;  2: return 2;  3: return 4;
      5: return -1; 6: return -2; 7: return -4;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bus responder and acknowledge monitor
  initial begin
    for (int i = 0; i < 16; i++) ack_seen[i] = 0;
    forever begin
      @(negedge clk);
      tick++;
      if (|periph_ack) begin
        ack_total++;
        for (int i = 0; i < 16; i++) if (periph_ack[i]) ack_seen[i]++;
        if (drop_mode) periph_req = periph_req & ~periph_ack;
      end
      if (m_valid && (tick % 3 != 0)) begin
        m_ready = 1'b1;
        m_rdata = pat(m_addr);
        m_err   = err_arm && !m_write && (m_addr == err_addr);
        if (log_n < 256) begin
          log_addr[log_n] = m_addr;
          log_data[log_n] = m_write ? m_wdata : pat(m_addr);
          log_size[log_n] = m_size;
          log_wr[log_n]   = m_write;
          log_sys[log_n]  = m_sys;
        end
        log_n++;
      end else begin
        m_ready = 1'b0;
        m_err   = 1'b0;
      end
    end
  end

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_finish(output bit done);
    logic [31:0] v;
    done = 0;
    for (int i = 0; i < 400 && !done; i++) begin
      reg_read(4'hC, v);
      if (v[1]) done = 1;
    end
  endtask

  task automatic wait_acks(input int k);
    for (int i = 0; i < 200 && ack_total < k; i++) @(negedge clk);
  endtask

  task automatic sweep_run(input int sc, input int dc, input bit burst, input int cnt,
                           input int width, input int sel);
    logic [31:0] s, d, v, ctrl;
    bit done;
    int beats, n;
    beats = burst ? 4 : 1;
    log_n = 0;
    reg_write(4'h0, 32'h0000_1000);
    reg_write(4'h4, 32'h0000_8000);
    reg_write(4'h8, 32'(cnt));
    ctrl = 32'h1 | (32'(burst) << 3) | (32'(sel) << 6) | (32'(sc) << 8) |
           (32'(dc) << 12) | (32'(width) << 20);
    reg_write(4'hC, ctrl);
    wait_finish(done);
    check(done, "R6 finish flag", 32'(done), 32'h1);
    n = cnt * beats * 2;
    check(log_n == n, "R5 beat count", 32'(log_n), 32'(n));
    s = 32'h1000; d = 32'h8000;
    for (int k = 0; k < n && k < log_n; k += 2) begin
      check(log_addr[k] == s && log_addr[k+1] == d, "R4 beat addresses",
            log_addr[k] ^ log_addr[k+1], s ^ d);
      check(!log_wr[k] && log_wr[k+1] && log_data[k+1] == pat(s) &&
            log_size[k] == 2'(width) && log_size[k+1] == 2'(width) &&
            log_sys[k] == sel[0] && log_sys[k+1] == sel[1],
            "R3 beat data/size/bus", log_data[k+1], pat(s));
      s = s + 32'(step_of(sc));
      d = d + 32'(step_of(dc));
    end
    reg_read(4'h0, v); check(v == s, "R4 final source", v, s);
    reg_read(4'h4, v); check(v == d, "R4 final destination", v, d);
    reg_read(4'h8, v); check(v == 0, "R6 count drained", v, 0);
    reg_read(4'hC, v); check(v[0] == 1'b0, "R6 enable cleared", v, ctrl & ~32'h1);
    reg_write(4'hC, 32'h0);
  endtask

  initial begin
    logic [31:0] v;
    bit done;

    // watchdog
    fork
      begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R1 reset state and register map
    reg_read(4'h0, v); check(v == 0, "R1 reset source", v, 0);
    reg_read(4'h4, v); check(v == 0, "R1 reset destination", v, 0);
    reg_read(4'h8, v); check(v == 0, "R1 reset count", v, 0);
    reg_read(4'hC, v); check(v == 0, "R1 reset control", v, 0);
    check(!irq && !m_valid, "R1 reset outputs", {30'b0, irq, m_valid}, 0);
    reg_write(4'h0, 32'h1234_5678);
    reg_read(4'h0, v); check(v == 32'h1234_5678, "R1 source readback", v, 32'h1234_5678);
    reg_write(4'h4, 32'h9ABC_DEF0);
    reg_read(4'h4, v); check(v == 32'h9ABC_DEF0, "R1 destination readback", v, 32'h9ABC_DEF0);
    reg_write(4'h8, 32'hFFFF_FFFF);
    reg_read(4'h8, v); check(v == 32'h00FF_FFFF, "R1 count width", v, 32'h00FF_FFFF);
    // R2: writing 1 to clear status bits leaves them 0
    reg_write(4'hC, 32'hFFFF_FFFE);
    reg_read(4'hC, v); check(v == 32'h0F3F_77EC, "R1 R2 control mask", v, 32'h0F3F_77EC);
    reg_write(4'hC, 32'h0);

    // R3 R4 sweep over every step-code pair
    for (int sc = 0; sc < 8; sc++)
      for (int dc = 0; dc < 8; dc++)
        sweep_run(sc, dc, bit'((sc + dc) % 2), 2, (sc + dc) % 3, dc % 4);

    // R6 zero count start, R8 finish interrupt, R2 status write semantics
    log_n = 0;
    reg_write(4'h8, 32'h0);
    reg_write(4'hC, 32'h5);
    idle(4);
    reg_read(4'hC, v); check(v == 32'h6, "R6 zero-count finish", v, 32'h6);
    check(log_n == 0, "R6 zero-count no bus access", 32'(log_n), 0);
    check(irq == 1'b1, "R8 finish interrupt", 32'(irq), 1);
    reg_write(4'hC, 32'h6);
    reg_read(4'hC, v); check(v == 32'h6, "R2 write 1 keeps finish", v, 32'h6);
    reg_write(4'hC, 32'h4);
    reg_read(4'hC, v); check(v == 32'h4, "R2 write 0 clears finish", v, 32'h4);
    idle(2);
    check(irq == 1'b0, "R8 interrupt drops", 32'(irq), 0);
    reg_write(4'hC, 32'h0);

    // R7 error response
    log_n = 0;
    err_arm = 1; err_addr = 32'h1001;
    reg_write(4'h0, 32'h1000);
    reg_write(4'h4, 32'h8000);
    reg_write(4'h8, 32'd4);
    reg_write(4'hC, 32'h1 | 32'h20 | (32'd1 << 8) | (32'd1 << 12));
    idle(40);
    check(log_n == 3, "R7 bus stops after error", 32'(log_n), 3);
    reg_read(4'hC, v); check(v[0] == 1'b0 && v[4] == 1'b1, "R7 error flag", v, 32'h1130);
    reg_read(4'h0, v); check(v == 32'h1001, "R7 failed read not stepped", v, 32'h1001);
    reg_read(4'h8, v); check(v == 32'd3, "R5 residue after error", v, 3);
    check(irq == 1'b1, "R8 error interrupt", 32'(irq), 1);
    reg_write(4'hC, 32'h30);
    reg_read(4'hC, v); check(v == 32'h30, "R2 write 1 keeps error", v, 32'h30);
    reg_write(4'hC, 32'h20);
    reg_read(4'hC, v); check(v == 32'h20, "R2 write 0 clears error", v, 32'h20);
    idle(2);
    check(irq == 1'b0, "R8 interrupt cleared", 32'(irq), 0);
    err_arm = 0;
    reg_write(4'hC, 32'h0);

    // R9 handshake, R5 live count, R10 write protection
    log_n = 0;
    for (int i = 0; i < 16; i++) ack_seen[i] = 0;
    ack_total = 0;
    periph_req = 16'h0004;
    reg_write(4'h0, 32'h1000);
    reg_write(4'h4, 32'h8000);
    reg_write(4'h8, 32'd3);
    reg_write(4'hC, 32'h1 | (32'd1 << 8) | (32'd1 << 12) | (32'd5 << 16) | (32'd2 << 24));
    idle(20);
    check(log_n == 0, "R9 waits for request", 32'(log_n), 0);
    reg_read(4'h8, v); check(v == 32'd3, "R5 count while waiting", v, 3);
    reg_write(4'h0, 32'h0000_DEAD);
    reg_read(4'h0, v); check(v == 32'h1000, "R10 source write ignored", v, 32'h1000);
    reg_write(4'h8, 32'd9);
    reg_read(4'h8, v); check(v == 32'd3, "R10 count write ignored", v, 3);
    drop_mode = 1;
    periph_req = 16'h0024;
    wait_acks(1);
    idle(10);
    check(log_n == 2, "R9 one cycle per request", 32'(log_n), 2);
    reg_read(4'h8, v); check(v == 32'd2, "R5 live residue", v, 2);
    periph_req = 16'h0024;
    wait_acks(2);
    idle(5);
    reg_read(4'h8, v); check(v == 32'd1, "R5 live residue second", v, 1);
    periph_req = 16'h0024;
    wait_acks(3);
    wait_finish(done);
    check(done, "R6 handshake transfer finishes", 32'(done), 1);
    check(ack_seen[2] == 3 && ack_seen[5] == 3 && ack_total == 3, "R9 acknowledge pulses",
          32'(ack_seen[2] * 256 + ack_seen[5] * 16 + ack_total), 32'h333);
    check(log_n == 6, "R9 total beats", 32'(log_n), 6);
    drop_mode = 0;
    periph_req = '0;
    reg_write(4'hC, 32'h0);

    idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule